// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block produces the instruction fetch address for a small microcontroller core. It keeps a 13-bit program counter. The counter's address space is 8K words, but program memory only has 1K words, so the block passes the counter's low ten bits to that memory. The counter's full width is kept internally, so a counter value above the implemented range wraps into the first 1K words at the memory side only.

Each cycle the core decode logic raises at most a few strobes: interrupt accept, plain jump, call, the three return flavours (plain, from interrupt, with literal) and stall. The block picks one action by fixed priority and updates the counter. Return addresses go to an eight-level circular hardware stack, which has no overflow or underflow indication.

Top module: `pcs_fetch_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) loads counter value 0 and empties the stack. It overrides every other input, stall included.
- R2: When no strobe and no stall is present, the counter advances by one each cycle and wraps from 1FFFh to 0000h.
- R3: `jump_en` or `call_en` loads the counter from `jump_tgt`. `call_en` also pushes the old counter value plus one.
- R4: `irq_take` loads counter value 0004h and pushes the old counter value plus one. It takes precedence over jump, call and every return.
- R5: Each of `ret_en`, `reti_en` and `retlw_en` pops the most recently pushed address into the counter.
- R6: When a call or jump and a return are raised in the same cycle, the branch wins and the stack is not popped.
- R7: The stack holds eight entries in a ring. A ninth push overwrites the oldest entry. A pop with the stack empty wraps the pointer and returns the entry at the wrapped position. Neither case is flagged.
- R8: While `stall` is high and reset is low, the counter and the stack stay unchanged, whatever strobes are present.
- R9: `fetch_addr` carries counter bits 9:0 with bits 12:10 forced to zero. The counter keeps all 13 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| irq_take | input | 1 | Interrupt accepted this cycle |
| jump_en | input | 1 | Unconditional jump to `jump_tgt` |
| call_en | input | 1 | Subroutine call to `jump_tgt` |
| ret_en | input | 1 | Plain return |
| reti_en | input | 1 | Return from interrupt |
| retlw_en | input | 1 | Return carrying a literal |
| stall | input | 1 | Hold counter and stack |
| jump_tgt | input | 13 | Branch target for jump and call |
| fetch_addr | output | 13 | Program memory address, folded to 1K words |

## Verification
The embedded properties expect every strobe to be a clean 0 or 1 at each rising edge, with no X values. They also expect that nothing but reset acts on a cycle in which reset is high. The pointer properties count each push or pop only once per edge. The stimulus changes inputs only on falling edges, keeps reset in the initial cycles and in two directed blocks, and raises conflicting strobes only on purpose to test priority. Because of this, every edge sees stable, fully defined controls.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam int PC_W     = 13;
    localparam int IMPL_W   = 10;
    localparam int STK_DEPTH = 8;
    localparam logic [PC_W-1:0] VEC_RESET = 13'h0000;
    localparam logic [PC_W-1:0] VEC_IRQ   = 13'h0004;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_IRQ,
        OP_BRANCH,
        OP_POP,
        OP_INC
    } pc_op_e;
endpackage

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
    parameter int W     = 13,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_val,
    output logic [W-1:0] top_val
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        ptr;
    } stk_t;

    stk_t st_d, st_q;
    logic [PTR_W-1:0] ptr_dec;

    assign ptr_dec = PTR_W'(st_q.ptr - 1'b1);
    assign top_val = st_q.mem[ptr_dec];

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.ptr] = push_val;
            st_d.ptr           = PTR_W'(st_q.ptr + 1'b1);
        end else if (pop) begin
            st_d.ptr = ptr_dec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R7: ring pointer moves up by one on push
    a_r7_push_advance: assert property (@(posedge clk) disable iff (rst)
        (push && !rst) |=> (st_q.ptr == PTR_W'($past(st_q.ptr) + 1'b1)));
    // R7: ring pointer moves down by one on pop
    a_r7_pop_retreat: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && !rst) |=> (st_q.ptr == PTR_W'($past(st_q.ptr) - 1'b1)));
    // R3: pushed value appears at the top next cycle
    a_r3_push_visible: assert property (@(posedge clk) disable iff (rst)
        (push && !rst) |=> (top_val == $past(push_val)));
endmodule

// File: rtl/pcs_fold.sv
module pcs_fold #(
    parameter int PC_W   = 13,
    parameter int IMPL_W = 10
) (
    input  logic [PC_W-1:0] pc_in,
    output logic [PC_W-1:0] addr_out
);
    generate
        if (IMPL_W >= PC_W) begin : g_full
            assign addr_out = pc_in;
        end else begin : g_fold
            assign addr_out = {{(PC_W-IMPL_W){1'b0}}, pc_in[IMPL_W-1:0]};
        end
    endgenerate
endmodule

// File: rtl/pcs_fetch_seq.sv
module pcs_fetch_seq
    import pcs_pkg::*;
#(
    parameter int CNT_W  = PC_W,
    parameter int MEM_W  = IMPL_W,
    parameter int DEPTH  = STK_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             irq_take,
    input  logic             jump_en,
    input  logic             call_en,
    input  logic             ret_en,
    input  logic             reti_en,
    input  logic             retlw_en,
    input  logic             stall,
    input  logic [CNT_W-1:0] jump_tgt,
    output logic [CNT_W-1:0] fetch_addr
);
    typedef struct packed {
        logic [CNT_W-1:0] pc;
    } seq_t;

    seq_t             seq_d, seq_q;
    pc_op_e           op;
    logic             stk_push, stk_pop;
    logic [CNT_W-1:0] stk_top, pc_inc;

    assign pc_inc = CNT_W'(seq_q.pc + 1'b1);

    always_comb begin
        if (stall)                            op = OP_HOLD;
        else if (irq_take)                    op = OP_IRQ;
        else if (jump_en || call_en)          op = OP_BRANCH;
        else if (ret_en || reti_en || retlw_en) op = OP_POP;
        else                                  op = OP_INC;
    end

    always_comb begin
        seq_d    = seq_q;
        stk_push = 1'b0;
        stk_pop  = 1'b0;
        unique case (op)
            OP_HOLD:   seq_d.pc = seq_q.pc;
            OP_IRQ: begin
                seq_d.pc = CNT_W'(VEC_IRQ);
                stk_push = 1'b1;
            end
            OP_BRANCH: begin
                seq_d.pc = jump_tgt;
                stk_push = call_en;
            end
            OP_POP: begin
                seq_d.pc = stk_top;
                stk_pop  = 1'b1;
            end
            default:   seq_d.pc = pc_inc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q.pc <= CNT_W'(VEC_RESET);
        else     seq_q    <= seq_d;
    end

    pcs_ret_stack #(.W(CNT_W), .DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (stk_push),
        .pop      (stk_pop),
        .push_val (pc_inc),
        .top_val  (stk_top)
    );

    pcs_fold #(.PC_W(CNT_W), .IMPL_W(MEM_W)) u_fold (
        .pc_in    (seq_q.pc),
        .addr_out (fetch_addr)
    );

    // R4: interrupt entry lands on the vector
    a_r4_irq_vector: assert property (@(posedge clk) disable iff (rst)
        (irq_take && !stall && !rst) |=> (seq_q.pc == CNT_W'(VEC_IRQ)));
    // R8: stall freezes the counter
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (stall && !rst) |=> $stable(seq_q.pc));
    // R3: jump without interrupt takes the target
    a_r3_jump_target: assert property (@(posedge clk) disable iff (rst)
        ((jump_en || call_en) && !irq_take && !stall && !rst) |=> (seq_q.pc == $past(jump_tgt)));
    // R2: idle cycle advances by one
    a_r2_increment: assert property (@(posedge clk) disable iff (rst)
        (!rst && !stall && !irq_take && !jump_en && !call_en && !ret_en && !reti_en && !retlw_en)
        |=> (seq_q.pc == CNT_W'($past(seq_q.pc) + 1'b1)));
    // R9: upper fetch bits never set
    a_r9_fold_high_zero: assert property (@(posedge clk) disable iff (rst)
        (fetch_addr >> MEM_W) == '0);
endmodule

// File: tb/pcs_fetch_seq_tb.sv
module pcs_fetch_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_take = 0, jump_en = 0, call_en = 0, ret_en = 0;
    logic        reti_en = 0, retlw_en = 0, stall = 0;
    logic [12:0] jump_tgt = '0;
    logic [12:0] fetch_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pcs_fetch_seq u_dut (
        .clk(clk), .rst(rst), .irq_take(irq_take), .jump_en(jump_en),
        .call_en(call_en), .ret_en(ret_en), .reti_en(reti_en),
        .retlw_en(retlw_en), .stall(stall), .jump_tgt(jump_tgt),
        .fetch_addr(fetch_addr)
    );

    // ctrl bits: [6]irq [5]jump [4]call [3]ret [2]reti [1]retlw [0]stall
    // vector: {req[3:0], ctrl[6:0], tgt[12:0], exp[12:0]}
    localparam int NV = 18;
    localparam logic [36:0] VEC [NV] = '{
        {4'd2, 7'b0000000, 13'h0000, 13'h0001},  // R2
        {4'd2, 7'b0000000, 13'h0000, 13'h0002},  // R2
        {4'd3, 7'b0010000, 13'h0100, 13'h0100},  // R3 call pushes 3
        {4'd2, 7'b0000000, 13'h0000, 13'h0101},  // R2
        {4'd9, 7'b0100000, 13'h1A05, 13'h0205},  // R9 fold of 1A05
        {4'd8, 7'b0000001, 13'h0000, 13'h0205},  // R8 stall
        {4'd4, 7'b1000000, 13'h0000, 13'h0004},  // R4 pushes 1A06
        {4'd2, 7'b0000000, 13'h0000, 13'h0005},  // R2
        {4'd5, 7'b0000100, 13'h0000, 13'h0206},  // R5 reti to 1A06
        {4'd9, 7'b0000000, 13'h0000, 13'h0207},  // R9 13-bit kept
        {4'd5, 7'b0001000, 13'h0000, 13'h0003},  // R5 ret
        {4'd6, 7'b0011000, 13'h0050, 13'h0050},  // R6 call beats ret
        {4'd5, 7'b0000010, 13'h0000, 13'h0004},  // R5 retlw
        {4'd4, 7'b1100000, 13'h0300, 13'h0004},  // R4 irq beats jump
        {4'd8, 7'b0001001, 13'h0000, 13'h0004},  // R8 stall blocks pop
        {4'd5, 7'b0001000, 13'h0000, 13'h0005},  // R5
        {4'd9, 7'b0100000, 13'h1FFF, 13'h03FF},  // R9
        {4'd2, 7'b0000000, 13'h0000, 13'h0000}   // R2 wrap
    };

    task automatic drive(input logic [6:0] c, input logic [12:0] t);
        {irq_take, jump_en, call_en, ret_en, reti_en, retlw_en, stall} = c;
        jump_tgt = t;
    endtask

    task automatic check(input int req, input logic [12:0] exp);
        n_chk++;
        if (fetch_addr !== exp) begin
            n_bad++;
            $display("FAIL R%0d: fetch_addr=%h expected=%h", req, fetch_addr, exp);
        end
    endtask

    task automatic step(input logic [6:0] c, input logic [12:0] t, input int req,
                        input logic [12:0] exp);
        drive(c, t);
        @(posedge clk); #1;
        check(req, exp);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check(1, 13'h0000);                        // R1 reset state
        rst = 1'b0;
        for (int i = 0; i < NV; i++)
            step(VEC[i][32:26], VEC[i][25:13], int'(VEC[i][36:33]), VEC[i][12:0]);

        // R1: reset beats interrupt and jump
        rst = 1'b1;
        drive(7'b1100001, 13'h0123);
        @(posedge clk); #1;
        check(1, 13'h0000);
        @(negedge clk);
        rst = 1'b0;
        drive(7'b0000000, 13'h0000);

        // R7: nine calls, then nine pops
        for (int k = 1; k <= 9; k++)
            step(7'b0010000, 13'(k * 16), 7, 13'(k * 16));
        for (int p = 1; p <= 8; p++)
            step((p % 2) ? 7'b0001000 : 7'b0000010, 13'h0000, 7,
                 13'(13'h081 - 16 * (p - 1)));
        step(7'b0000100, 13'h0000, 7, 13'h0081);   // R7 empty pop wraps

        // R1: reset clears stack pointer; push then pop returns fresh value
        rst = 1'b1;
        @(posedge clk); #1;
        check(1, 13'h0000);
        @(negedge clk);
        rst = 1'b0;
        step(7'b0010000, 13'h0200, 3, 13'h0200);   // R3 pushes 1
        step(7'b0001000, 13'h0000, 5, 13'h0001);   // R5

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule